// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a windowed watchdog with a small memory-mapped register interface. Software sets a 12-bit preload, a window code and a reaction code, then writes a fixed 32-bit arming word. From that clock on the watchdog runs and cannot be stopped. Its down-counter loads the preload shifted left by 13 bits and drops by one every clock. Software services it by writing a two-word key pair in order.

A completed pair reloads the counter only when the service window is open. With the half-window code selected, the window opens once the counter falls below half of the reload value. A counter that reaches zero, a pair completed while the window is closed, or a key word out of sequence each set their own sticky status flag. Any of them also raises one sticky reaction output: an interrupt line or a reset request, depending on the reaction code.

Top module: `wdog_window_top`

## Requirements
- R1: After reset, every register reads zero except the count register (0xA0), which reads 0x1FFFFFF, and both irq_o and rst_req_o are low.
- R2: The register offsets are as follows.
  - 0x90 is the arming register.
  - 0x94 holds the preload in bits [11:0].
  - 0x98 holds the status flags.
  - 0x9C is the key register, which reads zero.
  - 0xA0 holds the count in bits [24:0].
  - 0xA4 holds the reaction code in bits [7:0].
  - 0xA8 holds the window code in bits [7:0].
  Unmapped offsets read zero. Read data appears on reg_rdata on the clock after the clock that samples reg_re.
- R3: Writing 0xA98559DA to 0x90 arms the watchdog, and any other value written there is ignored. Once the watchdog is armed, 0x90 reads 0xA98559DA, and nothing short of reset disarms it.
- R4: The clock that samples the arming write loads the count with preload<<13. The count then decreases by one per clock, stops at zero, and holds its reset value while the watchdog is unarmed.
- R5: Writing 0x0000E51A and then 0x0000A35C to 0x9C reloads the count with preload<<13 on the clock that samples the second word, provided the window is open.
- R6: Writes to 0x94, 0xA4 and 0xA8 after arming are ignored.
- R7: Window code 0x50 opens the window only while count < (preload<<13)/2, and any other code keeps it always open. A pair completed while the window is closed sets status bit 1 and does not reload the count.
- R8: A count of zero while armed sets status bit 0 and triggers the reaction on the next clock.
- R9: Any word other than the one expected in either position of the key pair sets status bit 2. The sequence then restarts, expecting the first word.
- R10: Reaction code 0x0A makes any violation raise irq_o, and any other code makes it raise rst_req_o. The chosen output is raised on the same clock as the status flag and stays high until reset.
- R11: Writing a 1 to a status bit clears that bit, unless the same clock sets it again. Clearing a bit does not lower the reaction output and does not disarm the watchdog.
- R12: Writes to 0x9C before arming have no effect on the status register, the outputs or the key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_re | input | 1 | Read enable |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Sticky interrupt reaction |
| rst_req_o | output | 1 | Sticky reset-request reaction |

## Verification
Read data is due one clock after the clock that samples the read, so the bench samples reg_rdata at the falling edge that follows that clock. The count is loaded on the clock that samples the arming word or the second key word. A read issued straight afterwards therefore returns exactly the reload value, and each later clock takes one off it. The bench counts clocks from the arming write: it expects both outputs low on the clock where the count reaches zero and the chosen output high one clock later. The window boundary is probed exactly, with one service completing at a count of 4096 (closed) and one at 4095 (open) for a reload of 8192.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_ARM     = 8'h90;
    localparam logic [ADDR_W-1:0] OFS_PRELOAD = 8'h94;
    localparam logic [ADDR_W-1:0] OFS_FLAGS   = 8'h98;
    localparam logic [ADDR_W-1:0] OFS_KEY     = 8'h9C;
    localparam logic [ADDR_W-1:0] OFS_COUNT   = 8'hA0;
    localparam logic [ADDR_W-1:0] OFS_ACTION  = 8'hA4;
    localparam logic [ADDR_W-1:0] OFS_WINDOW  = 8'hA8;

    localparam logic [DATA_W-1:0] ARM_WORD  = 32'hA98559DA;
    localparam logic [DATA_W-1:0] SVC_WORD0 = 32'h0000E51A;
    localparam logic [DATA_W-1:0] SVC_WORD1 = 32'h0000A35C;

    localparam logic [7:0] ACT_IRQ  = 8'h0A;
    localparam logic [7:0] WIN_HALF = 8'h50;

    localparam int FLAG_TO    = 0;
    localparam int FLAG_EARLY = 1;
    localparam int FLAG_BAD   = 2;
    localparam int FLAG_W     = 3;

    typedef enum logic {
        KS_FIRST,
        KS_SECOND
    } key_state_e;
endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              key_we,
    input  logic [DATA_W-1:0] key_data,
    output logic              svc_done,
    output logic              bad_key
);
    typedef struct packed {
        key_state_e st;
    } ks_t;

    ks_t d, q;

    always_comb begin
        d        = q;
        svc_done = 1'b0;
        bad_key  = 1'b0;
        if (!armed) begin
            d.st = KS_FIRST;
        end else if (key_we) begin
            unique case (q.st)
                KS_FIRST: begin
                    if (key_data == SVC_WORD0) begin
                        d.st = KS_SECOND;
                    end else begin
                        bad_key = 1'b1;
                    end
                end
                KS_SECOND: begin
                    d.st = KS_FIRST;
                    if (key_data == SVC_WORD1) begin
                        svc_done = 1'b1;
                    end else begin
                        bad_key = 1'b1;
                    end
                end
                default: d.st = KS_FIRST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st <= KS_FIRST;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int PRELOAD_W = 12,
    parameter int SHIFT     = 13,
    parameter int CODE_W    = 8,
    localparam int CNT_W    = PRELOAD_W + SHIFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 armed,
    input  logic                 arm_start,
    input  logic                 svc_done,
    input  logic [PRELOAD_W-1:0] preload,
    input  logic [CODE_W-1:0]    window_code,
    output logic [CNT_W-1:0]     count,
    output logic                 svc_ok,
    output logic                 evt_timeout,
    output logic                 evt_early
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t d, q;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] half;
    logic             win_open;

    always_comb begin
        reload   = {preload, {SHIFT{1'b0}}};
        half     = reload >> 1;
        win_open = (window_code == CODE_W'(WIN_HALF)) ? (q.count < half) : 1'b1;

        svc_ok      = armed && svc_done && win_open;
        evt_early   = armed && svc_done && !win_open;
        evt_timeout = armed && (q.count == '0);

        d = q;
        if (arm_start) begin
            d.count = reload;
        end else if (armed) begin
            if (svc_ok) begin
                d.count = reload;
            end else if (q.count != '0) begin
                d.count = q.count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.count <= '1;
        end else begin
            q <= d;
        end
    end

    assign count = q.count;
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
#(
    parameter int PRELOAD_W = 12,
    parameter int SHIFT     = 13,
    parameter int CODE_W    = 8,
    localparam int CNT_W    = PRELOAD_W + SHIFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_we,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 reg_re,
    input  logic                 evt_timeout,
    input  logic                 evt_early,
    input  logic                 evt_bad,
    input  logic [CNT_W-1:0]     count,
    output logic                 armed,
    output logic                 arm_start,
    output logic [PRELOAD_W-1:0] preload,
    output logic [CODE_W-1:0]    action_code,
    output logic [CODE_W-1:0]    window_code,
    output logic [DATA_W-1:0]    reg_rdata
);
    typedef struct packed {
        logic                 armed;
        logic [PRELOAD_W-1:0] preload;
        logic [CODE_W-1:0]    action;
        logic [CODE_W-1:0]    window;
        logic [FLAG_W-1:0]    flags;
        logic [DATA_W-1:0]    rdata;
    } cfg_t;

    cfg_t d, q;

    always_comb begin
        d         = q;
        arm_start = 1'b0;

        if (reg_we && !q.armed) begin
            unique case (reg_addr)
                OFS_PRELOAD: d.preload = reg_wdata[PRELOAD_W-1:0];
                OFS_ACTION:  d.action  = reg_wdata[CODE_W-1:0];
                OFS_WINDOW:  d.window  = reg_wdata[CODE_W-1:0];
                OFS_ARM: begin
                    if (reg_wdata == ARM_WORD) begin
                        d.armed   = 1'b1;
                        arm_start = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (reg_we && (reg_addr == OFS_FLAGS)) begin
            d.flags = q.flags & ~reg_wdata[FLAG_W-1:0];
        end
        if (evt_timeout) d.flags[FLAG_TO]    = 1'b1;
        if (evt_early)   d.flags[FLAG_EARLY] = 1'b1;
        if (evt_bad)     d.flags[FLAG_BAD]   = 1'b1;

        d.rdata = '0;
        if (reg_re) begin
            unique case (reg_addr)
                OFS_ARM:     d.rdata = q.armed ? ARM_WORD : '0;
                OFS_PRELOAD: d.rdata[PRELOAD_W-1:0] = q.preload;
                OFS_FLAGS:   d.rdata[FLAG_W-1:0]    = q.flags;
                OFS_COUNT:   d.rdata[CNT_W-1:0]     = count;
                OFS_ACTION:  d.rdata[CODE_W-1:0]    = q.action;
                OFS_WINDOW:  d.rdata[CODE_W-1:0]    = q.window;
                default:     d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign armed       = q.armed;
    assign preload     = q.preload;
    assign action_code = q.action;
    assign window_code = q.window;
    assign reg_rdata   = q.rdata;
endmodule

// File: rtl/wdog_window_top.sv
module wdog_window_top
    import wdog_pkg::*;
#(
    parameter int PRELOAD_W = 12,
    parameter int SHIFT     = 13,
    parameter int CODE_W    = 8,
    localparam int CNT_W    = PRELOAD_W + SHIFT
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_addr,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    input  logic        reg_re,
    output logic [31:0] reg_rdata,
    output logic        irq_o,
    output logic        rst_req_o
);
    typedef struct packed {
        logic irq;
        logic rst_req;
    } react_t;

    react_t d, q;

    logic                 armed;
    logic                 arm_start;
    logic [PRELOAD_W-1:0] preload;
    logic [CODE_W-1:0]    action_code;
    logic [CODE_W-1:0]    window_code;
    logic [CNT_W-1:0]     count;
    logic                 svc_done;
    logic                 bad_key;
    logic                 svc_ok;
    logic                 evt_timeout;
    logic                 evt_early;
    logic                 key_we;

    assign key_we = reg_we && (reg_addr == OFS_KEY);

    wdog_cfg #(
        .PRELOAD_W (PRELOAD_W),
        .SHIFT     (SHIFT),
        .CODE_W    (CODE_W)
    ) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_re      (reg_re),
        .evt_timeout (evt_timeout),
        .evt_early   (evt_early),
        .evt_bad     (bad_key),
        .count       (count),
        .armed       (armed),
        .arm_start   (arm_start),
        .preload     (preload),
        .action_code (action_code),
        .window_code (window_code),
        .reg_rdata   (reg_rdata)
    );

    wdog_keyseq i_keyseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (armed),
        .key_we   (key_we),
        .key_data (reg_wdata),
        .svc_done (svc_done),
        .bad_key  (bad_key)
    );

    wdog_counter #(
        .PRELOAD_W (PRELOAD_W),
        .SHIFT     (SHIFT),
        .CODE_W    (CODE_W)
    ) i_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .armed       (armed),
        .arm_start   (arm_start),
        .svc_done    (svc_done),
        .preload     (preload),
        .window_code (window_code),
        .count       (count),
        .svc_ok      (svc_ok),
        .evt_timeout (evt_timeout),
        .evt_early   (evt_early)
    );

    always_comb begin
        d = q;
        if (evt_timeout || evt_early || bad_key) begin
            if (action_code == CODE_W'(ACT_IRQ)) begin
                d.irq = 1'b1;
            end else begin
                d.rst_req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign irq_o     = q.irq;
    assign rst_req_o = q.rst_req;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
    parameter int PRELOAD_W = 12,
    parameter int SHIFT     = 13,
    localparam int CNT_W    = PRELOAD_W + SHIFT
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 armed,
    input logic                 arm_start,
    input logic                 svc_ok,
    input logic [CNT_W-1:0]     count,
    input logic [PRELOAD_W-1:0] preload,
    input logic                 irq_o,
    input logic                 rst_req_o
);
    AST_ARMED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !arm_start) |=> $stable(count)); // R4

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !svc_ok && (count != '0)) |=> (count == ($past(count) - CNT_W'(1)))); // R4

    AST_COUNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !svc_ok && (count == '0)) |=> (count == '0)); // R4

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> (count == {$past(preload), {SHIFT{1'b0}}})); // R5

    AST_TIMEOUT_REACTS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (count == '0)) |=> (irq_o || rst_req_o)); // R8

    AST_ONE_REACTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && rst_req_o)); // R10

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> irq_o); // R10

    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> rst_req_o); // R10
endmodule

bind wdog_window_top wdog_checker #(
    .PRELOAD_W (PRELOAD_W),
    .SHIFT     (SHIFT)
) i_wdog_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (armed),
    .arm_start (arm_start),
    .svc_ok    (svc_ok),
    .count     (count),
    .preload   (preload),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
);

// File: tb/test_wdog_window_top.sv
`timescale 1ns/1ps
module test_wdog_window_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_re = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq_o;
    logic        rst_req_o;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [31:0] ARM  = 32'hA98559DA;
    localparam logic [31:0] K0   = 32'h0000E51A;
    localparam logic [31:0] K1   = 32'h0000A35C;
    localparam int          RLD1 = 8192;

    always #2.5 clk = ~clk;

    wdog_window_top i_wdog_window_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

    typedef struct packed {
        logic        is_wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'h94, 32'hFFFFF123, 32'h0},
        '{1'b0, 8'h94, 32'h0,        32'h00000123},
        '{1'b1, 8'hA4, 32'h1234560A, 32'h0},
        '{1'b0, 8'hA4, 32'h0,        32'h0000000A},
        '{1'b1, 8'hA8, 32'h00000150, 32'h0},
        '{1'b0, 8'hA8, 32'h0,        32'h00000050},
        '{1'b0, 8'h90, 32'h0,        32'h0},
        '{1'b1, 8'h90, 32'h12345678, 32'h0},
        '{1'b0, 8'h90, 32'h0,        32'h0},
        '{1'b0, 8'h98, 32'h0,        32'h0},
        '{1'b0, 8'hA0, 32'h0,        32'h01FFFFFF},
        '{1'b0, 8'h9C, 32'h0,        32'h0},
        '{1'b0, 8'h40, 32'h0,        32'h0}
    };

    // All tasks begin and end at a falling edge.
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        reg_we = 1'b0;
        reg_re = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] dat);
        reg_addr  = a;
        reg_wdata = dat;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] val);
        reg_addr = a;
        reg_re   = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        val    = reg_rdata;
    endtask

    task automatic setup(input logic [11:0] pl, input logic [7:0] act, input logic [7:0] win);
        wr(8'h94, {20'h0, pl});
        wr(8'hA4, {24'h0, act});
        wr(8'hA8, {24'h0, win});
        wr(8'h90, ARM);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;

        // R1: reset state
        do_reset();
        chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
        chk("R1 rst_req after reset", {31'h0, rst_req_o}, 32'h0);
        rd(8'hA0, v); chk("R1 count after reset", v, 32'h01FFFFFF);

        // R2 register map table (row 7 also covers R3 wrong arming word)
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].is_wr) begin
                wr(VECS[i].addr, VECS[i].data);
            end else begin
                rd(VECS[i].addr, v);
                chk($sformatf("R2 table row %0d", i), v, VECS[i].exp);
            end
        end
        rd(8'h90, v); chk("R3 wrong arming word ignored", v, 32'h0);

        // R3 R4 R6 R8 R10: arm, count, ignored reconfig, timeout to irq
        do_reset();
        setup(12'h001, 8'h0A, 8'h00);
        rd(8'hA0, v); chk("R4 load at arm", v, RLD1);
        rd(8'hA0, v); chk("R4 decrement", v, RLD1 - 1);
        wr(8'h94, 32'h5);
        rd(8'h94, v); chk("R6 preload locked", v, 32'h1);
        wr(8'h90, 32'h0);
        rd(8'h90, v); chk("R3 armed readback", v, ARM);
        repeat (RLD1 - 6) @(negedge clk);
        chk("R8 no reaction at zero clock", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R8 irq one clock after zero", {31'h0, irq_o}, 32'h1);
        chk("R10 rst_req stays low", {31'h0, rst_req_o}, 32'h0);
        rd(8'h98, v); chk("R8 timeout flag", v, 32'h1);
        rd(8'hA0, v); chk("R4 count held at zero", v, 32'h0);

        // R5 R10: service in full window, then timeout to rst_req
        do_reset();
        setup(12'h001, 8'h00, 8'h00);
        repeat (100) @(negedge clk);
        wr(8'h9C, K0);
        wr(8'h9C, K1);
        rd(8'hA0, v); chk("R5 reload on service", v, RLD1);
        rd(8'h98, v); chk("R5 no flag on service", v, 32'h0);
        repeat (RLD1 - 2) @(negedge clk);
        chk("R10 no reset request yet", {31'h0, rst_req_o}, 32'h0);
        @(negedge clk);
        chk("R10 reset request raised", {31'h0, rst_req_o}, 32'h1);
        chk("R10 irq stays low", {31'h0, irq_o}, 32'h0);

        // R7: early service in half window
        do_reset();
        setup(12'h001, 8'h0A, 8'h50);
        wr(8'h9C, K0);
        wr(8'h9C, K1);
        chk("R7 early service irq", {31'h0, irq_o}, 32'h1);
        rd(8'h98, v); chk("R7 early flag", v, 32'h2);

        // R7 boundary: count 4096 at completion is closed
        do_reset();
        setup(12'h001, 8'h0A, 8'h50);
        repeat (4095) @(negedge clk);
        wr(8'h9C, K0);
        wr(8'h9C, K1);
        rd(8'hA0, v); chk("R7 closed at half, no reload", v, 32'd4095);
        rd(8'h98, v); chk("R7 closed at half flag", v, 32'h2);

        // R7 boundary: count 4095 at completion is open
        do_reset();
        setup(12'h001, 8'h0A, 8'h50);
        repeat (4096) @(negedge clk);
        wr(8'h9C, K0);
        wr(8'h9C, K1);
        rd(8'hA0, v); chk("R7 open below half reload", v, RLD1);
        chk("R7 open below half no irq", {31'h0, irq_o}, 32'h0);

        // R9 R11: bad first word, clear flag
        do_reset();
        setup(12'h001, 8'h0A, 8'h00);
        wr(8'h9C, 32'h00001234);
        chk("R9 bad first word irq", {31'h0, irq_o}, 32'h1);
        rd(8'h98, v); chk("R9 bad key flag", v, 32'h4);
        wr(8'h98, 32'h4);
        rd(8'h98, v); chk("R11 flag cleared", v, 32'h0);
        chk("R11 irq stays high", {31'h0, irq_o}, 32'h1);
        rd(8'h90, v); chk("R11 still armed", v, ARM);

        // R9: bad second word, sequence restarts
        do_reset();
        setup(12'h001, 8'h00, 8'h00);
        wr(8'h9C, K0);
        wr(8'h9C, K0);
        chk("R9 bad second word rst_req", {31'h0, rst_req_o}, 32'h1);
        wr(8'h9C, K0);
        wr(8'h9C, K1);
        rd(8'hA0, v); chk("R9 restart then valid pair", v, RLD1);
        rd(8'h98, v); chk("R9 only bad key flag", v, 32'h4);

        // R12: key writes before arming
        do_reset();
        wr(8'h9C, K0);
        wr(8'h9C, 32'h55);
        rd(8'h98, v); chk("R12 no flag before arm", v, 32'h0);
        chk("R12 no output before arm", {30'h0, irq_o, rst_req_o}, 32'h0);
        setup(12'h001, 8'h0A, 8'h00);
        wr(8'h9C, K1);
        rd(8'h98, v); chk("R12 pre-arm word did not advance sequence", v, 32'h4);

        finish_run();
    end
endmodule